// File: doc/BRIEF.md
# Timer Input Capture Unit

This block pairs a 16-bit free-running up-counter with a capture register. When a capture trigger occurs, the register takes a snapshot of the running count. Software can then read the snapshot one byte at a time over a byte-wide register bus.

There are two trigger sources:
- A rising edge on an external capture input. The input is synchronised first.
- A bus write to either byte address of the capture register.

The capture register is read-only. A write therefore never stores its data byte; the write acts only as a software capture request. Every capture raises a sticky event flag, and a read of the high byte clears it.

Typical use is to time external events against the counter. Software can also sample the counter on demand without stopping it.

Top module: `tcap_unit`

## Requirements
- R1: After reset the counter is 0x0000. On each clock edge where `cnt_en` is high it adds one. While `cnt_en` is low it holds its value.
- R2: The counter wraps from 0xFFFF to 0x0000.
- R3: Suppose `cap_in` is low and is then first sampled high at clock edge k. After edge k+2 the capture register holds the count that was present just before edge k+2.
- R4: Each rising edge of `cap_in` produces exactly one capture. Holding `cap_in` high produces no further captures.
- R5: A `bus_wr` to address BASE_ADDR or BASE_ADDR+1 captures the count present in the write cycle. The data on `bus_wdata` is discarded.
- R6: `bus_rdata` shows the low byte of the capture register at BASE_ADDR and the high byte at BASE_ADDR+1. Any other address reads 0x00, and a write to any other address makes no capture.
- R7: `cap_flag` is set by every capture and cleared by a `bus_rd` at BASE_ADDR+1. A read at BASE_ADDR leaves it unchanged. If a capture and a clearing read fall in the same cycle, the flag ends up set.
- R8: An external trigger and a software trigger in the same cycle produce a single capture of that cycle's count.
- R9: `cap_flag` is low after reset. The capture register content is undefined until the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter increment enable |
| cap_in | input | 1 | Asynchronous external capture input |
| bus_addr | input | ADDR_W (8) | Register address |
| bus_wr | input | 1 | Write strobe; at a capture address it triggers a capture |
| bus_rd | input | 1 | Read strobe; at the high-byte address it clears the flag |
| bus_wdata | input | 8 | Write data (discarded) |
| bus_rdata | output | 8 | Read data for the addressed byte |
| cap_flag | output | 1 | Sticky capture event flag |

## Verification
The hardest cases are the coincidences: an external edge landing in the same cycle as a software write, and a capture landing in the same cycle as the flag-clearing read. The stimulus reaches the first case by raising `cap_in` and asserting the write exactly two cycles later, when the synchronised pulse is high. It reaches the second by driving a write and a read to the high-byte address together. The wrap at 0xFFFF cannot be preloaded. The bench therefore lets the counter run until it reaches 0xFFFF, gates `cnt_en` off there, captures, then releases one increment and captures again.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  count_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } sel_e;

    typedef struct packed {
        logic wr;
        logic rd;
        sel_e sel;
    } bus_req_t;

    function automatic byte_t pick_byte(input count_t value, input logic upper);
        return upper ? value[CNT_W-1:DATA_W] : value[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/tcap_counter.sv
module tcap_counter
    import tcap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    output count_t cnt
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (en)
            cnt <= cnt + count_t'(1);
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> cnt == count_t'($past(cnt) + count_t'(1)));

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

endmodule

// File: rtl/tcap_edge_sync.sv
module tcap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic pulse
);

    localparam int LAST = STAGES;

    logic [LAST:0] shreg;

    always_ff @(posedge clk) begin
        if (rst)
            shreg <= '0;
        else
            shreg <= {shreg[LAST-1:0], din};
    end

    assign pulse = shreg[LAST-1] & ~shreg[LAST];

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/tcap_capture.sv
module tcap_capture
    import tcap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cap_stb,
    input  logic   flag_clr,
    input  count_t cnt_i,
    output count_t cap_q,
    output logic   flag
);

    always_ff @(posedge clk) begin
        if (cap_stb)
            cap_q <= cnt_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (cap_stb)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> flag);

    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !cap_stb) |=> !flag);

    // R3
    cap_load_chk: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> cap_q == $past(cnt_i));

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              cap_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cap_flag
);

    localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(1);

    bus_req_t req;
    count_t   count;
    count_t   snap;
    logic     ext_pulse;
    logic     sw_trig;
    logic     cap_stb;
    byte_t    unused_wdata;

    assign unused_wdata = bus_wdata;

    always_comb begin
        req.wr = bus_wr;
        req.rd = bus_rd;
        if (bus_addr == BASE_ADDR)
            req.sel = SEL_LO;
        else if (bus_addr == HI_ADDR)
            req.sel = SEL_HI;
        else
            req.sel = SEL_NONE;
    end

    assign sw_trig = req.wr && (req.sel != SEL_NONE);
    assign cap_stb = ext_pulse | sw_trig;

    tcap_counter u_counter (
        .clk (clk),
        .rst (rst),
        .en  (cnt_en),
        .cnt (count)
    );

    tcap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (cap_in),
        .pulse (ext_pulse)
    );

    tcap_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .cap_stb  (cap_stb),
        .flag_clr (req.rd && (req.sel == SEL_HI)),
        .cnt_i    (count),
        .cap_q    (snap),
        .flag     (cap_flag)
    );

    always_comb begin
        unique case (req.sel)
            SEL_LO:  bus_rdata = pick_byte(snap, 1'b0);
            SEL_HI:  bus_rdata = pick_byte(snap, 1'b1);
            default: bus_rdata = '0;
        endcase
    end

    // R8
    dual_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_pulse && sw_trig) |=> (cap_flag && snap == $past(count)));

endmodule

// File: tb/test_tcap_unit.sv
module test_tcap_unit;

    localparam logic [7:0] BASE = 8'h20;
    localparam logic [7:0] HI   = 8'h21;

    // kind[23:16]: 0 write lo, 1 write hi, 2 external edge, 3 both, 4 write elsewhere
    // gap[15:8], wdata[7:0]
    localparam int NV = 7;
    localparam logic [23:0] VEC [NV] = '{
        {8'd0, 8'd3,  8'hA5},
        {8'd1, 8'd10, 8'h5A},
        {8'd2, 8'd7,  8'h00},
        {8'd3, 8'd4,  8'hFF},
        {8'd4, 8'd2,  8'h33},
        {8'd2, 8'd20, 8'h00},
        {8'd1, 8'd0,  8'hC3}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       cap_in = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cap_flag;

    logic [15:0] m;
    logic [15:0] expv;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) m <= 16'h0000;
        else if (cnt_en) m <= m + 16'h0001;
    end

    tcap_unit i_tcap_unit (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cap_in(cap_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_flag(cap_flag)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // called at a negedge; ends at a negedge with the flag cleared
    task automatic verify(input string tag, input logic [15:0] exp, input logic expf);
        bus_addr = BASE; #1;
        chk({tag, " lo byte (R6)"}, {8'h00, bus_rdata}, {8'h00, exp[7:0]});
        bus_addr = HI; #1;
        chk({tag, " hi byte (R6)"}, {8'h00, bus_rdata}, {8'h00, exp[15:8]});
        chk({tag, " flag (R7)"}, {15'd0, cap_flag}, {15'd0, expf});
        bus_addr = BASE; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        chk({tag, " lo read keeps flag R7"}, {15'd0, cap_flag}, {15'd0, expf});
        bus_addr = HI; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        chk({tag, " hi read clears flag R7"}, {15'd0, cap_flag}, 16'd0);
    endtask

    task automatic sw_cap(input logic [7:0] addr, input logic [7:0] data);
        bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
        expv = m;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 flag low after reset
        chk("R9 flag after reset", {15'd0, cap_flag}, 16'd0);
        bus_addr = 8'h55; #1;
        chk("R6 unmapped read", {8'h00, bus_rdata}, 16'h0000);
        // R1 counter starts at zero (counter held)
        repeat (3) @(negedge clk);
        sw_cap(BASE, 8'h77);
        verify("R1 reset count", 16'h0000, 1'b1);
        cnt_en = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [7:0] kind;
            logic [7:0] gap;
            logic [7:0] wd;
            logic [15:0] prev;
            string tag;
            kind = VEC[i][23:16];
            gap  = VEC[i][15:8];
            wd   = VEC[i][7:0];
            prev = expv;
            repeat (int'(gap)) @(negedge clk);
            case (kind)
                8'd0: begin tag = "R5 write lo"; sw_cap(BASE, wd); end
                8'd1: begin tag = "R5 write hi"; sw_cap(HI, wd); end
                8'd2: begin
                    tag = "R3 external edge";
                    cap_in = 1'b1; expv = m + 16'd2;
                    repeat (3) @(negedge clk);
                    cap_in = 1'b0;
                end
                8'd3: begin
                    tag = "R8 both triggers";
                    cap_in = 1'b1;
                    repeat (2) @(negedge clk);
                    sw_cap(BASE, wd);
                    cap_in = 1'b0;
                end
                default: begin
                    tag = "R6 write elsewhere";
                    sw_cap(BASE + 8'd2, wd);
                    expv = prev;
                end
            endcase
            verify(tag, expv, kind != 8'd4);
            repeat (3) @(negedge clk);
        end

        // R4 held-high input: one capture only
        cap_in = 1'b1; expv = m + 16'd2;
        repeat (3) @(negedge clk);
        verify("R4 first edge", expv, 1'b1);
        repeat (6) @(negedge clk);
        chk("R4 no recapture flag", {15'd0, cap_flag}, 16'd0);
        bus_addr = HI; #1;
        chk("R4 value unchanged", {8'h00, bus_rdata}, {8'h00, expv[15:8]});
        cap_in = 1'b0;
        repeat (4) @(negedge clk);

        // R7 capture and clearing read in the same cycle
        bus_addr = HI; bus_wr = 1'b1; bus_rd = 1'b1; expv = m;
        @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R7 set wins over clear", {15'd0, cap_flag}, 16'd1);
        verify("R7 same-cycle value", expv, 1'b1);

        // R1 hold and R2 wrap
        while (m != 16'hFFFF) @(negedge clk);
        cnt_en = 1'b0;
        sw_cap(BASE, 8'h01);
        verify("R2 at top", 16'hFFFF, 1'b1);
        repeat (5) @(negedge clk);
        sw_cap(HI, 8'h02);
        verify("R1 hold while disabled", 16'hFFFF, 1'b1);
        cnt_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0;
        sw_cap(BASE, 8'h03);
        verify("R2 wrap to zero", 16'h0000, 1'b1);

        finish_run();
    end

endmodule